// File: doc/BRIEF.md
# Next Program Counter Selector

This block decides where instruction fetch goes next. Each cycle it takes the current program counter, the decoded instruction fields and the control bits from decode. It then picks one of four addresses: the sequential address, a conditional branch target, a pseudo-direct jump target, or a target taken from a register. The choice is captured in an output register on the rising clock edge. That register also holds a PC-update strobe, which is raised whenever fetch is redirected away from the sequential path.

For the linking jumps, the block also returns the address of the following instruction. It raises a write request so that write-back can store that address in a register. Both conditional branch kinds are decided from the ALU zero flag. When several control bits are raised at once, a fixed priority settles the choice, so the result is always defined.

Top module: `npc_unit`

## Requirements
- R1: While rst_ni is low, and after it goes low at any time, next_pc_o equals RESET_PC (default 0) and pc_we_o, link_o and link_we_o are all 0.
- R2: Every output is registered. A change at the inputs appears at the outputs only after the next rising edge of clk_i, and it appears there at that edge.
- R3: With no control bit set (beq_i, bne_i, jump_i, jreg_i all 0), next_pc_o is pc_i + 4 modulo 2^32 and pc_we_o is 0.
- R4: A branch-if-equal (beq_i = 1) is taken when zero_i = 1. The taken target is pc_i + 4 plus the 16-bit imm_i sign-extended and multiplied by 4, modulo 2^32. When beq_i = 1 and zero_i = 0, and no other control bit is set, the result is pc_i + 4 with pc_we_o = 0.
- R5: A branch-if-not-equal (bne_i = 1) is taken when zero_i = 0, and it uses the same target as R4. If beq_i and bne_i are both 1, the branch is taken if either of the two conditions holds.
- R6: An immediate jump (jump_i = 1) gives next_pc_o = {pc_i[31:28], jidx_i[25:0], 2'b00}.
- R7: A register jump (jreg_i = 1) gives next_pc_o = rs_val_i, all 32 bits unchanged.
- R8: When more than one control bit is set, the priority from highest to lowest is jreg_i, then jump_i, then a taken branch, then pc_i + 4. pc_we_o is 1 exactly when one of the first three applies.
- R9: When link_i = 1 together with jump_i or jreg_i, link_we_o is 1 and link_o is pc_i + 4.
- R10: When link_i = 1 with neither jump_i nor jreg_i set, link_we_o is 0 and link_o is 0. This holds even when a branch is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Current program counter |
| imm_i | input | 16 | Branch offset in words, two's complement |
| jidx_i | input | 26 | Jump index field |
| rs_val_i | input | 32 | Register value for a register jump |
| zero_i | input | 1 | ALU zero flag |
| beq_i | input | 1 | Branch-if-equal control |
| bne_i | input | 1 | Branch-if-not-equal control |
| jump_i | input | 1 | Immediate jump control |
| jreg_i | input | 1 | Register jump control |
| link_i | input | 1 | Link request for the jump |
| next_pc_o | output | 32 | Selected next program counter |
| pc_we_o | output | 1 | PC redirect strobe |
| link_o | output | 32 | Return address (pc + 4) when linking |
| link_we_o | output | 1 | Link write-back request |

## Verification
A taken branch can land in the same cycle as an immediate jump or a register jump. A linking jump can also coincide with a conditional branch whose condition holds. The bench provokes these cases by sweeping all 32 combinations of the five control bits against both values of the zero flag, over address patterns chosen to make each candidate target distinct. These include negative and extreme offsets and a counter that wraps at the top of memory. Each result is judged against a priority model computed arithmetically in the bench, and that model also checks that the link request follows only the jumps.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JIMM   = 2'd2,
    NPC_JREG   = 2'd3
  } npc_src_e;
endpackage

// File: rtl/npc_branch.sv
module npc_branch #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  seq_pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             zero_i,
  input  logic             beq_i,
  input  logic             bne_i,
  output logic             taken_o,
  output logic [XLEN-1:0]  target_o
);
  localparam int EXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] offset;

  assign offset   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign target_o = seq_pc_i + offset;
  assign taken_o  = (beq_i & zero_i) | (bne_i & ~zero_i);
endmodule

// File: rtl/npc_jump.sv
module npc_jump #(
  parameter int XLEN   = 32,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-JIDX_W-3:0] pc_hi_i,
  input  logic [JIDX_W-1:0]      jidx_i,
  output logic [XLEN-1:0]        target_o
);
  // region bits from the current PC, word index, byte offset zero
  assign target_o = {pc_hi_i, jidx_i, 2'b00};
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            jreg_i,
  input  logic            jump_i,
  input  logic            br_taken_i,
  input  logic [XLEN-1:0] seq_pc_i,
  input  logic [XLEN-1:0] br_pc_i,
  input  logic [XLEN-1:0] jimm_pc_i,
  input  logic [XLEN-1:0] jreg_pc_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            redirect_o
);
  npc_src_e src;

  always_comb begin
    if (jreg_i)          src = NPC_JREG;
    else if (jump_i)     src = NPC_JIMM;
    else if (br_taken_i) src = NPC_BRANCH;
    else                 src = NPC_SEQ;
  end

  always_comb begin
    unique case (src)
      NPC_JREG:   next_pc_o = jreg_pc_i;
      NPC_JIMM:   next_pc_o = jimm_pc_i;
      NPC_BRANCH: next_pc_o = br_pc_i;
      default:    next_pc_o = seq_pc_i;
    endcase
  end

  assign redirect_o = (src != NPC_SEQ);
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int          XLEN     = 32,
  parameter int          IMM_W    = 16,
  parameter int          JIDX_W   = 26,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic              zero_i,
  input  logic              beq_i,
  input  logic              bne_i,
  input  logic              jump_i,
  input  logic              jreg_i,
  input  logic              link_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              pc_we_o,
  output logic [XLEN-1:0]   link_o,
  output logic              link_we_o
);
  localparam int              PC_HI_W = XLEN - JIDX_W - 2;
  localparam logic [XLEN-1:0] STEP    = XLEN'(4);
  localparam logic [XLEN-1:0] RST_PC  = XLEN'(RESET_PC);

  logic [XLEN-1:0] seq_pc, br_pc, jimm_pc, sel_pc;
  logic            br_taken, redirect, do_link;

  assign seq_pc  = pc_i + STEP;
  assign do_link = link_i & (jump_i | jreg_i);

  npc_branch #(.XLEN(XLEN), .IMM_W(IMM_W)) u_branch (
    .seq_pc_i (seq_pc),
    .imm_i    (imm_i),
    .zero_i   (zero_i),
    .beq_i    (beq_i),
    .bne_i    (bne_i),
    .taken_o  (br_taken),
    .target_o (br_pc)
  );

  npc_jump #(.XLEN(XLEN), .JIDX_W(JIDX_W)) u_jump (
    .pc_hi_i  (pc_i[XLEN-1 -: PC_HI_W]),
    .jidx_i   (jidx_i),
    .target_o (jimm_pc)
  );

  npc_select #(.XLEN(XLEN)) u_select (
    .jreg_i     (jreg_i),
    .jump_i     (jump_i),
    .br_taken_i (br_taken),
    .seq_pc_i   (seq_pc),
    .br_pc_i    (br_pc),
    .jimm_pc_i  (jimm_pc),
    .jreg_pc_i  (rs_val_i),
    .next_pc_o  (sel_pc),
    .redirect_o (redirect)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o <= RST_PC;
      pc_we_o   <= 1'b0;
      link_o    <= '0;
      link_we_o <= 1'b0;
    end else begin
      next_pc_o <= sel_pc;
      pc_we_o   <= redirect;
      link_o    <= do_link ? seq_pc : '0;
      link_we_o <= do_link;
    end
  end

  AST_SEQ_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!beq_i && !bne_i && !jump_i && !jreg_i)
      |=> (next_pc_o == $past(pc_i) + STEP) && !pc_we_o); // R3

  AST_BEQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beq_i && zero_i && !jump_i && !jreg_i) |=> pc_we_o); // R4

  AST_BNE_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bne_i && !zero_i && !jump_i && !jreg_i) |=> pc_we_o); // R5

  AST_JIMM_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !jreg_i)
      |=> pc_we_o && (next_pc_o[XLEN-1 -: PC_HI_W] == $past(pc_i[XLEN-1 -: PC_HI_W]))
          && (next_pc_o[JIDX_W+1:2] == $past(jidx_i)) && (next_pc_o[1:0] == 2'b00)); // R6

  AST_JREG_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jreg_i |=> pc_we_o && (next_pc_o == $past(rs_val_i))); // R7

  AST_LINK_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_i && (jump_i || jreg_i)) |=> link_we_o && (link_o == $past(pc_i) + STEP)); // R9

  AST_NO_LINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && !jreg_i) |=> !link_we_o && (link_o == '0)); // R10

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !pc_we_o && !link_we_o); // R1
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NPAT       = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0, rs_val_i = '0;
  logic [15:0] imm_i = '0;
  logic [25:0] jidx_i = '0;
  logic        zero_i = 0, beq_i = 0, bne_i = 0, jump_i = 0, jreg_i = 0, link_i = 0;
  logic [31:0] next_pc_o, link_o;
  logic        pc_we_o, link_we_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] e_pc, e_link;
  logic        e_we, e_lwe;
  string       e_req, e_lreq;

  npc_unit dut (
    .clk_i, .rst_ni, .pc_i, .imm_i, .jidx_i, .rs_val_i, .zero_i,
    .beq_i, .bne_i, .jump_i, .jreg_i, .link_i,
    .next_pc_o, .pc_we_o, .link_o, .link_we_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model();
    logic [31:0] seq, br, jt;
    logic        taken;
    seq   = pc_i + 32'd4;
    br    = seq + {{14{imm_i[15]}}, imm_i, 2'b00};
    jt    = {pc_i[31:28], jidx_i, 2'b00};
    taken = (beq_i && zero_i) || (bne_i && !zero_i);
    if (jreg_i) begin
      e_pc = rs_val_i; e_we = 1;
      e_req = (jump_i || beq_i || bne_i) ? "R8" : "R7";
    end else if (jump_i) begin
      e_pc = jt; e_we = 1;
      e_req = (beq_i || bne_i) ? "R8" : "R6";
    end else if (taken) begin
      e_pc = br; e_we = 1;
      e_req = (beq_i && bne_i) ? "R5" : (beq_i ? "R4" : "R5");
    end else begin
      e_pc = seq; e_we = 0;
      e_req = beq_i ? "R4" : (bne_i ? "R5" : "R3");
    end
    e_lwe  = link_i && (jump_i || jreg_i);
    e_link = e_lwe ? seq : 32'h0;
    e_lreq = e_lwe ? "R9" : "R10";
  endtask

  task automatic set_pat(input int p);
    case (p)
      0: begin pc_i = 32'h0040_0100; imm_i = 16'h0010; jidx_i = 26'h012_3456; rs_val_i = 32'hDEAD_BEEF; end
      1: begin pc_i = 32'h1000_0000; imm_i = 16'hFFFF; jidx_i = 26'h3FF_FFFF; rs_val_i = 32'h0000_0004; end
      2: begin pc_i = 32'hFFFF_FFFC; imm_i = 16'h7FFF; jidx_i = 26'h000_0001; rs_val_i = 32'h8000_0000; end
      3: begin pc_i = 32'h0000_0000; imm_i = 16'h8000; jidx_i = 26'h2AA_AAAA; rs_val_i = 32'h1234_5678; end
      4: begin pc_i = 32'hA5A5_A5A4; imm_i = 16'hFF00; jidx_i = 26'h155_5555; rs_val_i = 32'hFFFF_FFFF; end
      default: begin pc_i = 32'h7000_0040; imm_i = 16'h0001; jidx_i = 26'h000_0000; rs_val_i = 32'h0000_0000; end
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state while held
    repeat (3) @(negedge clk_i);
    chk("R1", "next_pc_o", next_pc_o, 32'h0);
    chk("R1", "pc_we_o", {31'b0, pc_we_o}, 32'h0);
    chk("R1", "link_o", link_o, 32'h0);
    chk("R1", "link_we_o", {31'b0, link_we_o}, 32'h0);
    rst_ni = 1'b1;

    for (int p = 0; p < NPAT; p++) begin
      for (int c = 0; c < 32; c++) begin
        for (int z = 0; z < 2; z++) begin
          set_pat(p);
          {link_i, jreg_i, jump_i, bne_i, beq_i} = 5'(c);
          zero_i = z[0];
          model();
          @(negedge clk_i);
          chk(e_req, "next_pc_o", next_pc_o, e_pc);
          chk(e_req, "pc_we_o", {31'b0, pc_we_o}, {31'b0, e_we});
          chk(e_lreq, "link_we_o", {31'b0, link_we_o}, {31'b0, e_lwe});
          chk(e_lreq, "link_o", link_o, e_link);
        end
      end
    end

    // R2: output holds until the next rising edge, then updates
    set_pat(0);
    {link_i, jreg_i, jump_i, bne_i, beq_i} = 5'b00000;
    @(negedge clk_i);
    {link_i, jreg_i, jump_i, bne_i, beq_i} = 5'b11000;
    #1;
    chk("R2", "next_pc_o before edge", next_pc_o, 32'h0040_0104);
    chk("R2", "link_we_o before edge", {31'b0, link_we_o}, 32'h0);
    @(negedge clk_i);
    chk("R2", "next_pc_o after edge", next_pc_o, 32'hDEAD_BEEF);
    chk("R2", "link_o after edge", link_o, 32'h0040_0104);

    // R1: asynchronous reset in mid-run
    #2 rst_ni = 1'b0;
    #1;
    chk("R1", "async next_pc_o", next_pc_o, 32'h0);
    chk("R1", "async pc_we_o", {31'b0, pc_we_o}, 32'h0);
    chk("R1", "async link_we_o", {31'b0, link_we_o}, 32'h0);
    @(negedge clk_i);
    chk("R1", "held link_o", link_o, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule